// File: doc/BRIEF.md
# Two-Channel Cycle-Stealing DMA Controller

This block moves data between memory locations on behalf of a processor that shares the same bus. It has two channels. Each channel holds a 20-bit source pointer, a 20-bit destination pointer, a 16-bit transfer counter and a 16-bit reload value. A request on a channel comes from one of two places: a rising edge on that channel's interrupt-request input, or a software write to the channel's control register. When a request is accepted, the controller asks the processor for the bus and waits for the grant. It then reads one unit into an internal latch and writes that unit to the destination. After the write it releases the bus again, so the processor loses only the cycles of that one move.

After each move, one pointer of the channel advances: the source pointer or the destination pointer, as the channel is configured. The counter also steps down. When a channel finishes its last programmed move, the counter refills from the reload value and the channel's done output rises. The channel then turns itself off unless it is in repeat mode. Requests that arrive while the channel already has a move pending merge into that one move. The controller never acknowledges or clears the interrupt-request inputs, and it does not look at any interrupt masking or priority.

Top module: `dma_steal_top`

## Requirements
- R1: After reset the following are all 0: bus_req, bus_rd, bus_wr, bus_byte, chan_done and every register of both channels.
- R2: The register select codes are 0 source pointer, 1 destination pointer, 2 reload, 3 counter and 4 control. A write to reload also loads the counter. Every register reads back, zero-extended, on reg_rdata for the channel given by reg_ch.
- R3: The control register bits are: bit0 enable, bit1 unit size (1 = 16 bits), bit2 forward select (0 = source pointer moves, 1 = destination pointer moves), bit3 repeat, bit4 software request and bit5 done. Bit4 is write-only and reads as 0. Bit5 is read-only. Any control write clears done.
- R4: A request is one of two events: a control write with bit4 = 1, or a 0-to-1 change on irq_req for that channel. If irq_req stays high, no further request is made.
- R5: A transfer runs in this order. bus_req rises. Then, in the cycle after bus_gnt is seen, comes one read cycle (bus_rd, with bus_addr equal to the source pointer). Next comes one write cycle (bus_wr, with bus_addr equal to the destination pointer and bus_wdata equal to the latched read data). bus_req is low in the cycle after the write. A new bus_req waits until bus_gnt is low.
- R6: In 16-bit mode bus_byte is 0 and the moving pointer advances by 2. In 8-bit mode bus_byte is 1, the moving pointer advances by 1, and bus_wdata carries the low byte of the read data with the upper byte at zero.
- R7: After each transfer only the pointer chosen by the forward select bit changes. The other pointer keeps its value.
- R8: Each transfer lowers the counter by one. If the counter held 1 or 0 before the transfer, it is reloaded from the reload register instead, chan_done rises, and enable is cleared unless repeat is 1.
- R9: Any number of requests that arrive while a transfer on the same channel is pending produce exactly one transfer.
- R10: When both channels become pending together, channel 0 is transferred first.
- R11: A request on a channel whose enable bit is 0 is ignored and produces no bus activity. Clearing enable also drops any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel being accessed |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data (combinational) |
| irq_req | input | 2 | Per-channel interrupt-request inputs |
| chan_done | output | 2 | Per-channel terminal-count flags |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_byte | output | 1 | 1 = 8-bit cycle |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid in the read cycle |

## Verification
Some rules are checked by the embedded properties on every cycle:
- each read cycle is granted and is followed at once by a write cycle;
- the bus request drops after the write;
- at most one pointer of a channel changes per move;
- a disabled channel never holds a pending request;
- channel 0 wins when both channels compete;
- the counter refills at the end of a block.

Other behaviour can only be shown by the bench scenarios, which compare every bus move against a queue of expected moves:
- requests that merge into one move;
- an interrupt level held high that does not retrigger;
- software requests on a disabled channel that are ignored;
- enable that stays set in repeat mode;
- register read-back values after each move.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned DEF_ADDR_W = 20;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_NCH    = 2;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_RLD  = 3'd2;
  localparam logic [2:0] SEL_CNT  = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_U16  = 1;
  localparam int unsigned CB_FWD  = 2;
  localparam int unsigned CB_RPT  = 3;
  localparam int unsigned CB_SWRQ = 4;
  localparam int unsigned CB_DONE = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } bus_st_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              irq_in,
  input  logic              step,
  input  logic [2:0]        rd_sel,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              unit16_o,
  output logic              pend_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] rdata_o
);
  localparam int unsigned CTRL_W = CB_DONE + 1;

  logic [ADDR_W-1:0] src_q, src_n, dst_q, dst_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, rld_q, rld_n;
  logic en_q, en_n, u16_q, u16_n, fwd_q, fwd_n, rpt_q, rpt_n;
  logic done_q, done_n, pend_q, pend_n, irq_q;
  logic ctrl_wr, req, last, edge_seen;
  logic [ADDR_W-1:0] inc;

  assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
  assign edge_seen = irq_in && !irq_q;
  assign last      = (cnt_q <= CNT_W'(1));
  assign inc       = u16_q ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    en_n  = en_q;
    u16_n = u16_q;
    fwd_n = fwd_q;
    rpt_n = rpt_q;
    if (step && last && !rpt_q) en_n = 1'b0;
    if (ctrl_wr) begin
      en_n  = wr_data[CB_EN];
      u16_n = wr_data[CB_U16];
      fwd_n = wr_data[CB_FWD];
      rpt_n = wr_data[CB_RPT];
    end
  end

  assign req    = edge_seen || (ctrl_wr && wr_data[CB_SWRQ]);
  assign pend_n = en_n && (req || (pend_q && !step));

  always_comb begin
    src_n = src_q;
    dst_n = dst_q;
    if (step && !fwd_q) src_n = src_q + inc;
    if (step && fwd_q)  dst_n = dst_q + inc;
    if (wr_en && wr_sel == SEL_SRC) src_n = wr_data;
    if (wr_en && wr_sel == SEL_DST) dst_n = wr_data;
  end

  always_comb begin
    cnt_n = cnt_q;
    rld_n = rld_q;
    if (step) cnt_n = last ? rld_q : cnt_q - CNT_W'(1);
    if (wr_en && wr_sel == SEL_CNT) cnt_n = wr_data[CNT_W-1:0];
    if (wr_en && wr_sel == SEL_RLD) begin
      rld_n = wr_data[CNT_W-1:0];
      cnt_n = wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    done_n = done_q;
    if (ctrl_wr)      done_n = 1'b0;
    if (step && last) done_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      rld_q  <= '0;
      en_q   <= 1'b0;
      u16_q  <= 1'b0;
      fwd_q  <= 1'b0;
      rpt_q  <= 1'b0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      src_q  <= src_n;
      dst_q  <= dst_n;
      cnt_q  <= cnt_n;
      rld_q  <= rld_n;
      en_q   <= en_n;
      u16_q  <= u16_n;
      fwd_q  <= fwd_n;
      rpt_q  <= rpt_n;
      done_q <= done_n;
      pend_q <= pend_n;
      irq_q  <= irq_in;
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_SRC:  rdata_o = src_q;
      SEL_DST:  rdata_o = dst_q;
      SEL_RLD:  rdata_o = ADDR_W'(rld_q);
      SEL_CNT:  rdata_o = ADDR_W'(cnt_q);
      SEL_CTRL: rdata_o = ADDR_W'({done_q, 1'b0, rpt_q, fwd_q, u16_q, en_q});
      default:  rdata_o = '0;
    endcase
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign unit16_o = u16_q;
  assign pend_o   = pend_q;
  assign done_o   = done_q;

  AST_DISABLED_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pend_q); // R11
  AST_ONE_POINTER_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en) |=> ($stable(src_q) || $stable(dst_q))); // R7
  AST_COUNT_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !wr_en) |=> (cnt_q == $past(rld_q))); // R8
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_pkg::*;
#(
  parameter int unsigned NCH  = DEF_NCH,
  parameter int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  pend,
  input  logic            bus_gnt,
  output bus_st_e         state_o,
  output logic [CH_W-1:0] act_o,
  output logic [NCH-1:0]  step_o
);
  bus_st_e         st_q, st_n;
  logic [CH_W-1:0] act_q, act_n, pick;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick = CH_W'(i);
    end
  end

  always_comb begin
    st_n  = st_q;
    act_n = act_q;
    unique case (st_q)
      ST_IDLE: if ((|pend) && !bus_gnt) begin
        st_n  = ST_REQ;
        act_n = pick;
      end
      ST_REQ: begin
        if (!pend[act_q])  st_n = ST_IDLE;
        else if (bus_gnt)  st_n = ST_RD;
      end
      ST_RD:   st_n = ST_WR;
      ST_WR:   st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      act_q <= '0;
    end else begin
      st_q  <= st_n;
      act_q <= act_n;
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_step
      assign step_o[g] = (st_q == ST_WR) && (act_q == CH_W'(g));
    end
  endgenerate

  assign state_o = st_q;
  assign act_o   = act_q;

  AST_LOW_CHANNEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && pend[0] && !bus_gnt) |=> (act_q == '0)); // R10
  AST_READ_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD) |-> $past(bus_gnt)); // R5
endmodule

// File: rtl/dma_steal_top.sv
module dma_steal_top
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned NCH    = DEF_NCH,
  parameter int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [CH_W-1:0]   reg_ch,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    irq_req,
  output logic [NCH-1:0]    chan_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned BYTE_W = DATA_W / 2;

  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  logic [ADDR_W-1:0] src_a [NCH];
  logic [ADDR_W-1:0] dst_a [NCH];
  logic [ADDR_W-1:0] rd_a  [NCH];
  logic [NCH-1:0]    u16_v, pend_v, step_v;
  bus_st_e           st;
  logic [CH_W-1:0]   act;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
        .clk      (clk),
        .rst_n    (rst_i),
        .wr_en    (reg_we && (reg_ch == CH_W'(g))),
        .wr_sel   (reg_sel),
        .wr_data  (reg_wdata),
        .irq_in   (irq_req[g]),
        .step     (step_v[g]),
        .rd_sel   (reg_sel),
        .src_o    (src_a[g]),
        .dst_o    (dst_a[g]),
        .unit16_o (u16_v[g]),
        .pend_o   (pend_v[g]),
        .done_o   (chan_done[g]),
        .rdata_o  (rd_a[g])
      );
    end
  endgenerate

  dma_bus_fsm #(.NCH(NCH), .CH_W(CH_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_i),
    .pend    (pend_v),
    .bus_gnt (bus_gnt),
    .state_o (st),
    .act_o   (act),
    .step_o  (step_v)
  );

  logic [DATA_W-1:0] latch_q, latch_n;
  logic              cap;

  assign cap     = (st == ST_RD);
  assign latch_n = cap ? bus_rdata : latch_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) latch_q <= '0;
    else        latch_q <= latch_n;
  end

  assign bus_req  = (st != ST_IDLE);
  assign bus_rd   = (st == ST_RD);
  assign bus_wr   = (st == ST_WR);
  assign bus_byte = (bus_rd || bus_wr) && !u16_v[act];

  always_comb begin
    bus_addr = '0;
    if (bus_rd) bus_addr = src_a[act];
    if (bus_wr) bus_addr = dst_a[act];
  end

  always_comb begin
    bus_wdata = '0;
    if (bus_wr) bus_wdata = bus_byte ? DATA_W'(latch_q[BYTE_W-1:0]) : latch_q;
  end

  assign reg_rdata = rd_a[reg_ch];

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_i)
    bus_rd |=> bus_wr); // R5
  AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_i)
    bus_wr |=> !bus_req); // R5
  AST_READ_GRANTED: assert property (@(posedge clk) disable iff (!rst_i)
    bus_rd |-> bus_gnt); // R5
endmodule

// File: tb/sim_dma_steal_top.sv
module sim_dma_steal_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [0:0]  reg_ch;
  logic [2:0]  reg_sel;
  logic [19:0] reg_wdata, reg_rdata;
  logic [1:0]  irq_req, chan_done;
  logic        bus_req, bus_gnt, bus_rd, bus_wr, bus_byte;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        gnt_allow;

  always #5 clk = ~clk;

  dma_steal_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .chan_done(chan_done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [15:0] memf(input logic [19:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  assign bus_rdata = memf(bus_addr);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && gnt_allow;
  end

  typedef struct packed {
    logic [19:0] ra;
    logic [19:0] wa;
    logic [15:0] d;
    logic        b;
  } item_t;

  item_t sbq[$];
  int    nchk = 0, nfail = 0, nwr = 0;
  bit    finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [19:0] cap_ra;
  logic        prev_wr = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wr) check(!bus_req, "R5 request after write", {31'd0, bus_req}, 32'd0);
      if (bus_rd) begin
        cap_ra = bus_addr;
        check(bus_gnt, "R5 read without grant", {31'd0, bus_gnt}, 32'd1);
      end
      if (bus_wr) begin
        nwr++;
        if (sbq.size() == 0) check(1'b0, "R11 unexpected transfer", {12'd0, bus_addr}, 32'd0);
        else begin
          item_t e;
          e = sbq.pop_front();
          check(cap_ra == e.ra, "R5 read address", {12'd0, cap_ra}, {12'd0, e.ra});
          check(bus_addr == e.wa, "R5 write address", {12'd0, bus_addr}, {12'd0, e.wa});
          check(bus_wdata == e.d, "R6 write data", {16'd0, bus_wdata}, {16'd0, e.d});
          check(bus_byte == e.b, "R6 unit size", {31'd0, bus_byte}, {31'd0, e.b});
        end
      end
      prev_wr = bus_wr;
    end
  end

  task automatic push(input logic [19:0] s, input logic [19:0] d, input bit byte_m);
    item_t e;
    e.ra = s;
    e.wa = d;
    e.b  = byte_m;
    e.d  = byte_m ? {8'h00, memf(s)[7:0]} : memf(s);
    sbq.push_back(e);
  endtask

  task automatic wreg(input bit ch, input logic [2:0] sel, input logic [19:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input bit ch, input logic [2:0] sel, output logic [19:0] v);
    @(negedge clk);
    reg_ch = ch; reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic rcheck(input bit ch, input logic [2:0] sel, input logic [19:0] exp, input string req);
    logic [19:0] v;
    rreg(ch, sel, v);
    check(v == exp, req, {12'd0, v}, {12'd0, exp});
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int w0;
    rst_n = 1'b0; reg_we = 1'b0; reg_ch = 1'b0; reg_sel = 3'd0; reg_wdata = '0;
    irq_req = 2'b00; gnt_allow = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!bus_req && !bus_rd && !bus_wr && !bus_byte, "R1 bus idle", {28'd0, bus_req, bus_rd, bus_wr, bus_byte}, 32'd0);
    check(chan_done == 2'b00, "R1 done", {30'd0, chan_done}, 32'd0);
    rcheck(0, 3'd0, 20'h0, "R1 source reset");
    rcheck(1, 3'd4, 20'h0, "R1 control reset");

    // R2 register map and read-back
    wreg(0, 3'd0, 20'h12340);
    wreg(0, 3'd1, 20'h56780);
    wreg(0, 3'd2, 20'h00003);
    rcheck(0, 3'd0, 20'h12340, "R2 source");
    rcheck(0, 3'd1, 20'h56780, "R2 destination");
    rcheck(0, 3'd2, 20'h00003, "R2 reload");
    rcheck(0, 3'd3, 20'h00003, "R2 counter loaded by reload");

    // R3 R6 R7 word transfer by software request, source moves
    push(20'h12340, 20'h56780, 1'b0);
    wreg(0, 3'd4, 20'h13);
    settle();
    check(nwr == 1, "R3 software request", nwr, 1);
    rcheck(0, 3'd0, 20'h12342, "R6 word step");
    rcheck(0, 3'd1, 20'h56780, "R7 destination kept");
    rcheck(0, 3'd3, 20'h00002, "R8 counter decrement");
    rcheck(0, 3'd4, 20'h03, "R3 control read, request bit reads 0");

    // R4 R6 R7 byte transfer by irq edge, destination moves; level held
    wreg(1, 3'd0, 20'h00100);
    wreg(1, 3'd1, 20'h00200);
    wreg(1, 3'd2, 20'h00005);
    wreg(1, 3'd4, 20'h05);
    push(20'h00100, 20'h00200, 1'b1);
    @(negedge clk); irq_req[1] = 1'b1;
    repeat (30) @(negedge clk);
    check(nwr == 2, "R4 held level gives one transfer", nwr, 2);
    rcheck(1, 3'd1, 20'h00201, "R6 byte step");
    rcheck(1, 3'd0, 20'h00100, "R7 source kept");
    rcheck(1, 3'd3, 20'h00004, "R8 counter decrement ch1");
    irq_req[1] = 1'b0;
    push(20'h00100, 20'h00201, 1'b1);
    repeat (2) @(negedge clk); irq_req[1] = 1'b1;
    @(negedge clk); irq_req[1] = 1'b0;
    settle();
    check(nwr == 3, "R4 new edge", nwr, 3);
    rcheck(1, 3'd1, 20'h00202, "R6 byte step again");

    // R8 terminal count on ch0 (counter 2)
    push(20'h12342, 20'h56780, 1'b0);
    wreg(0, 3'd4, 20'h13);
    settle();
    push(20'h12344, 20'h56780, 1'b0);
    wreg(0, 3'd4, 20'h13);
    settle();
    check(nwr == 5, "R8 two more transfers", nwr, 5);
    rcheck(0, 3'd3, 20'h00003, "R8 counter reloaded");
    check(chan_done[0], "R8 done raised", {30'd0, chan_done}, 32'd1);
    rcheck(0, 3'd4, 20'h22, "R8 enable cleared, done bit");

    // R11 request while disabled is ignored; control write clears done
    wreg(0, 3'd4, 20'h12);
    settle();
    check(nwr == 5, "R11 disabled request ignored", nwr, 5);
    check(!chan_done[0], "R8 done cleared by control write", {30'd0, chan_done}, 32'd0);
    @(negedge clk); irq_req[0] = 1'b1;
    settle();
    irq_req[0] = 1'b0;
    check(nwr == 5, "R11 disabled irq ignored", nwr, 5);

    // R8 repeat mode keeps enable
    wreg(1, 3'd2, 20'h00001);
    wreg(1, 3'd4, 20'h0D);
    push(20'h00100, 20'h00202, 1'b1);
    @(negedge clk); irq_req[1] = 1'b1;
    @(negedge clk); irq_req[1] = 1'b0;
    settle();
    check(nwr == 6, "R8 repeat transfer", nwr, 6);
    check(chan_done[1], "R8 repeat done", {30'd0, chan_done}, 32'd2);
    rcheck(1, 3'd4, 20'h2D, "R8 repeat keeps enable");
    rcheck(1, 3'd3, 20'h00001, "R8 repeat reload");

    // R9 merged requests while bus is held
    gnt_allow = 1'b0;
    push(20'h12346, 20'h56780, 1'b0);
    wreg(0, 3'd4, 20'h13);
    wreg(0, 3'd4, 20'h13);
    wreg(0, 3'd4, 20'h13);
    repeat (6) @(negedge clk);
    check(nwr == 6, "R5 no transfer without grant", nwr, 6);
    gnt_allow = 1'b1;
    settle();
    check(nwr == 7, "R9 requests merged", nwr, 7);
    rcheck(0, 3'd3, 20'h00002, "R9 counter stepped once");

    // R10 both channels pending together
    gnt_allow = 1'b0;
    push(20'h12348, 20'h56780, 1'b0);
    push(20'h00100, 20'h00203, 1'b1);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 1'b0; reg_sel = 3'd4; reg_wdata = 20'h13;
    irq_req[1] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; irq_req[1] = 1'b0;
    repeat (4) @(negedge clk);
    w0 = nwr;
    gnt_allow = 1'b1;
    settle(); settle();
    check(nwr == w0 + 2, "R10 both channels served", nwr, w0 + 2);
    check(sbq.size() == 0, "R10 all expected moves seen", sbq.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule